// File: doc/BRIEF.md
# Host Multiplexed Memory Access Port

This block lets an external host read and write the chip's internal program and data memories over one 16-bit bus that carries both addresses and data. The host drives four active-low strobes: select, read, write and address latch. The block answers with a busy line. The strobes are asynchronous to the core clock, so each one passes through a synchroniser before the block acts on it. A control register holds the current word address and a memory-type bit. The host loads this register with an address-latch cycle, and the core can overwrite it directly. After every completed word the address steps by one, so a host can stream a block of words after a single latch.

Data-memory words are 16 bits wide and move in one bus cycle each. Program-memory words are 24 bits wide and move in two bus cycles. The upper 16 bits go first, and the low byte follows on bus bits 7:0. On a read, the second half is served from a holding register without touching memory. On a write, the first half waits in a holding register and memory is written once the second half arrives. Every memory access waits for a cycle-steal grant from the core.

The host can run long cycles, where it waits for busy to fall, or short cycles. On a short read, the host takes the word fetched by the previous read, which stays on the bus while the new fetch runs. On a short write, the host releases the strobe before busy falls.

Top module: `hostMemPort`

## Requirements
- R1: While select and address-latch are both asserted, the bus value is loaded into the control register. Bits 13:0 become the word address. Bit 14 selects the memory: 0 is program, 1 is data. Bit 15 is dropped and reads back as 0 on `ctlRegOut`. The register is never driven onto the host bus.
- R2: `hostBusy` is low after reset. It goes high at the third rising clock edge after a read or write starts, and it falls once that access has finished.
- R3: A data-memory read or write moves one 16-bit word. The address increments by one after each word.
- R4: A program-memory read returns word bits 23:8 first. The second read returns `{8'h00, word[7:0]}` with no memory access. The address increments only after the second half.
- R5: The first half of a program-memory write is held without a steal request or a memory write. The second half writes `{first[15:0], second[7:0]}`, ignores bits 15:8 of the second half, and increments the address.
- R6: An address latch or a core write to the control register that comes between the two halves discards the pending half. Memory is left unchanged, and the next access counts as a first half.
- R7: A memory read or write happens only in a cycle where `stealReq` and `stealGnt` are both high. While no grant comes, `hostBusy` stays high and no access happens.
- R8: If the grant is held high, a data-memory read puts its word on `busOut` and drops `hostBusy` at the fifth rising edge after the strobes are asserted.
- R9: While a new read fetch is in progress, `busOut` keeps showing the word from the previous read.
- R10: `busOe` is high exactly while the select and read pins are both low. It follows the pins directly, with no clock in the path.
- R11: A core write (`coreCtlWr`) loads the control register with the same field layout as R1, and it takes effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low reset |
| hostSelN | input | 1 | Host select, active low, asynchronous |
| hostRdN | input | 1 | Host read strobe, active low |
| hostWrN | input | 1 | Host write strobe, active low |
| hostAleN | input | 1 | Host address-latch strobe, active low |
| busIn | input | 16 | Value the host drives on the shared bus |
| busOut | output | 16 | Value the port drives on the shared bus |
| busOe | output | 1 | Bus output enable |
| hostBusy | output | 1 | High while an access is in progress |
| coreCtlWr | input | 1 | Core write strobe for the control register |
| coreCtlData | input | 16 | Value the core writes to the control register |
| ctlRegOut | output | 16 | Control register as seen by the core |
| stealReq | output | 1 | Request for a memory cycle |
| stealGnt | input | 1 | Grant for the requested cycle |
| memAddr | output | 14 | Memory word address |
| memIsData | output | 1 | 1 selects data memory, 0 selects program memory |
| memRdEn | output | 1 | Memory read; data is expected one cycle later |
| memWrEn | output | 1 | Memory write |
| memWrData | output | 24 | Write word; data memory uses bits 15:0 |
| memRdData | input | 24 | Read word; data memory supplies bits 15:0 |

## Verification
Most internal faults in this port show up at the host within one access. A wrong address counter shows up as the wrong word on the next read, or as memory written at the wrong address. A half-pending flag left set or cleared in error swaps the upper and lower halves of a program word on the very next read. It also writes program memory one bus cycle too early or too late, and the memory counters and the final memory comparison catch that. The faults seen only later are a missed discard of a pending half, which corrupts memory only when the next write completes, and a prefetch register updated too early, which the short-read sample taken while busy is high catches.

// File: rtl/hmpPkg.sv
package hmpPkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDREQ,
    ST_RDRESP,
    ST_RDLOW,
    ST_WRREQ,
    ST_WRACK
  } hmpState_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic ldHost;    // host address latch into control register
    logic capWr;     // capture bus value as write data
    logic holdWr;    // park first program half in holding register
    logic takeRd;    // take memory read data
    logic takeLow;   // present held low byte
    logic bump;      // step the address
    logic dropHalf;  // clear pending half
  } hmpStrobe_t;
endpackage

// File: rtl/hmpSync.sv
module hmpSync #(
  parameter int NUM    = 4,
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [NUM-1:0] pinN,
  output logic [NUM-1:0] active
);
  for (genvar g = 0; g < NUM; g++) begin : gSync
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[STAGES-2:0], ~pinN[g]};
    end
    assign active[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/hmpCtrl.sv
module hmpCtrl
  import hmpPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       selA,
  input  logic       rdA,
  input  logic       wrA,
  input  logic       aleA,
  input  logic       isData,
  input  logic       halfPend,
  input  logic       stealGnt,
  output hmpStrobe_t strobe,
  output logic       hostBusy,
  output logic       stealReq,
  output logic       memRdEn,
  output logic       memWrEn
);
  hmpState_e state, nextState;
  logic rdPrev, wrPrev, alePrev;
  logic rdAct, wrAct, aleAct;
  logic rdStart, wrStart, aleStart;

  assign rdAct  = selA & rdA;
  assign wrAct  = selA & wrA;
  assign aleAct = selA & aleA;
  assign rdStart  = rdAct & ~rdPrev;
  assign wrStart  = wrAct & ~wrPrev;
  assign aleStart = aleAct & ~alePrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      rdPrev  <= 1'b0;
      wrPrev  <= 1'b0;
      alePrev <= 1'b0;
    end else begin
      state   <= nextState;
      rdPrev  <= rdAct;
      wrPrev  <= wrAct;
      alePrev <= aleAct;
    end
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    memRdEn   = 1'b0;
    memWrEn   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (aleStart) begin
          strobe.ldHost = 1'b1;
        end else if (rdStart) begin
          nextState = (!isData && halfPend) ? ST_RDLOW : ST_RDREQ;
        end else if (wrStart) begin
          if (!isData && !halfPend) begin
            strobe.holdWr = 1'b1;
            nextState     = ST_WRACK;
          end else begin
            strobe.capWr = 1'b1;
            nextState    = ST_WRREQ;
          end
        end
      end
      ST_RDREQ: begin
        if (stealGnt) begin
          memRdEn   = 1'b1;
          nextState = ST_RDRESP;
        end
      end
      ST_RDRESP: begin
        strobe.takeRd = 1'b1;
        strobe.bump   = isData;
        nextState     = ST_IDLE;
      end
      ST_RDLOW: begin
        strobe.takeLow  = 1'b1;
        strobe.bump     = 1'b1;
        strobe.dropHalf = 1'b1;
        nextState       = ST_IDLE;
      end
      ST_WRREQ: begin
        if (stealGnt) begin
          memWrEn         = 1'b1;
          strobe.bump     = 1'b1;
          strobe.dropHalf = 1'b1;
          nextState       = ST_IDLE;
        end
      end
      ST_WRACK: nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  assign hostBusy = (state != ST_IDLE);
  assign stealReq = (state == ST_RDREQ) || (state == ST_WRREQ);
endmodule

// File: rtl/hmpData.sv
module hmpData
  import hmpPkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int ADDR_W = 14,
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  hmpStrobe_t        strobe,
  input  logic [BUS_W-1:0]  busIn,
  input  logic              coreCtlWr,
  input  logic [BUS_W-1:0]  coreCtlData,
  input  logic [WORD_W-1:0] memRdData,
  output logic [BUS_W-1:0]  busOut,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWrData,
  output logic              isData,
  output logic              halfPend,
  output logic [BUS_W-1:0]  ctlRegOut
);
  localparam int LOW_W = WORD_W - BUS_W;
  localparam int PAD_W = BUS_W - ADDR_W - 1;

  logic [BUS_W-1:0]  busReg;
  logic [ADDR_W-1:0] ctlAddr;
  logic [BUS_W-1:0]  halfData;
  logic [BUS_W-1:0]  wrCap;
  logic [BUS_W-1:0]  outReg;
  logic              unusedCoreTop;

  assign unusedCoreTop = ^coreCtlData[BUS_W-1:ADDR_W+1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busReg <= '0;
    else       busReg <= busIn;
  end

  // control register: host latch, then core write, then auto step
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlAddr <= '0;
      isData  <= 1'b0;
    end else if (strobe.ldHost) begin
      ctlAddr <= busReg[ADDR_W-1:0];
      isData  <= busReg[ADDR_W];
    end else if (coreCtlWr) begin
      ctlAddr <= coreCtlData[ADDR_W-1:0];
      isData  <= coreCtlData[ADDR_W];
    end else if (strobe.bump) begin
      ctlAddr <= ctlAddr + 1'b1;
    end
  end

  // holding register for the split program word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfPend <= 1'b0;
      halfData <= '0;
    end else if (strobe.ldHost || coreCtlWr) begin
      halfPend <= 1'b0;
    end else if (strobe.holdWr) begin
      halfPend <= 1'b1;
      halfData <= busReg;
    end else if (strobe.takeRd && !isData) begin
      halfPend <= 1'b1;
      halfData <= {{(BUS_W-LOW_W){1'b0}}, memRdData[LOW_W-1:0]};
    end else if (strobe.dropHalf) begin
      halfPend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             wrCap <= '0;
    else if (strobe.capWr) wrCap <= busReg;
  end

  // read output register doubles as the short-read prefetch buffer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg <= '0;
    end else if (strobe.takeRd) begin
      outReg <= isData ? memRdData[BUS_W-1:0] : memRdData[WORD_W-1:LOW_W];
    end else if (strobe.takeLow) begin
      outReg <= {{(BUS_W-LOW_W){1'b0}}, halfData[LOW_W-1:0]};
    end
  end

  assign busOut    = outReg;
  assign memAddr   = ctlAddr;
  assign memWrData = isData ? {{LOW_W{1'b0}}, wrCap}
                            : {halfData, wrCap[LOW_W-1:0]};
  assign ctlRegOut = {{PAD_W{1'b0}}, isData, ctlAddr};
endmodule

// File: rtl/hostMemPort.sv
module hostMemPort
  import hmpPkg::*;
#(
  parameter int BUS_W   = 16,
  parameter int ADDR_W  = 14,
  parameter int WORD_W  = 24,
  parameter int SYNC_ST = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSelN,
  input  logic              hostRdN,
  input  logic              hostWrN,
  input  logic              hostAleN,
  input  logic [BUS_W-1:0]  busIn,
  output logic [BUS_W-1:0]  busOut,
  output logic              busOe,
  output logic              hostBusy,
  input  logic              coreCtlWr,
  input  logic [BUS_W-1:0]  coreCtlData,
  output logic [BUS_W-1:0]  ctlRegOut,
  output logic              stealReq,
  input  logic              stealGnt,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memIsData,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [WORD_W-1:0] memWrData,
  input  logic [WORD_W-1:0] memRdData
);
  logic [3:0] pinAct;
  hmpStrobe_t strobe;
  logic isData, halfPend;

  hmpSync #(.NUM(4), .STAGES(SYNC_ST)) u_sync (
    .clk(clk), .rstN(rstN),
    .pinN({hostAleN, hostWrN, hostRdN, hostSelN}),
    .active(pinAct)
  );

  hmpCtrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .selA(pinAct[0]), .rdA(pinAct[1]), .wrA(pinAct[2]), .aleA(pinAct[3]),
    .isData(isData), .halfPend(halfPend), .stealGnt(stealGnt),
    .strobe(strobe), .hostBusy(hostBusy), .stealReq(stealReq),
    .memRdEn(memRdEn), .memWrEn(memWrEn)
  );

  hmpData #(.BUS_W(BUS_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busIn(busIn),
    .coreCtlWr(coreCtlWr), .coreCtlData(coreCtlData), .memRdData(memRdData),
    .busOut(busOut), .memAddr(memAddr), .memWrData(memWrData),
    .isData(isData), .halfPend(halfPend), .ctlRegOut(ctlRegOut)
  );

  assign busOe     = ~hostSelN & ~hostRdN;
  assign memIsData = isData;
endmodule

// File: rtl/hostMemPortChk.sv
module hostMemPortChk #(
  parameter int BUS_W  = 16,
  parameter int ADDR_W = 14
) (
  input logic             clk,
  input logic             rstN,
  input logic             hostBusy,
  input logic             stealReq,
  input logic             stealGnt,
  input logic             memRdEn,
  input logic             memWrEn,
  input logic             memIsData,
  input logic             coreCtlWr,
  input logic [BUS_W-1:0] ctlRegOut
);
  // R7
  mem_needs_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn || memWrEn) |-> (stealGnt && hostBusy));

  // R2
  idle_no_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hostBusy |-> !stealReq);

  // R3
  write_steps_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && !coreCtlWr) |=>
      ctlRegOut[ADDR_W-1:0] == ADDR_W'($past(ctlRegOut[ADDR_W-1:0]) + 1'b1));

  // R3
  read_issue_holds_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && !coreCtlWr) |=> $stable(ctlRegOut));

  // R4
  prog_first_half_no_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && !memIsData && !coreCtlWr) ##1 !coreCtlWr |=>
      ctlRegOut == $past(ctlRegOut, 2));
endmodule

bind hostMemPort hostMemPortChk #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_hostMemPortChk (
  .clk(clk), .rstN(rstN), .hostBusy(hostBusy), .stealReq(stealReq),
  .stealGnt(stealGnt), .memRdEn(memRdEn), .memWrEn(memWrEn),
  .memIsData(memIsData), .coreCtlWr(coreCtlWr), .ctlRegOut(ctlRegOut)
);

// File: tb/hostMemPort_bench.sv
module hostMemPort_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostSelN = 1'b1, hostRdN = 1'b1, hostWrN = 1'b1, hostAleN = 1'b1;
  logic [15:0] busIn = '0;
  logic [15:0] busOut;
  logic busOe, hostBusy;
  logic coreCtlWr = 1'b0;
  logic [15:0] coreCtlData = '0;
  logic [15:0] ctlRegOut;
  logic stealReq;
  logic stealGnt = 1'b1;
  logic [13:0] memAddr;
  logic memIsData, memRdEn, memWrEn;
  logic [23:0] memWrData;
  logic [23:0] memRdData = '0;

  always #10 clk = ~clk;

  hostMemPort u_hostMemPort (.*);

  // bench-side memories and their expected shadows
  logic [23:0] pm [64];
  logic [15:0] dm [64];
  logic [23:0] shPm [64];
  logic [15:0] shDm [64];
  int rdCount = 0, wrCount = 0;

  always @(posedge clk) begin
    if (memRdEn) begin
      memRdData <= memIsData ? {8'h00, dm[memAddr[5:0]]} : pm[memAddr[5:0]];
      rdCount <= rdCount + 1;
    end
    if (memWrEn) begin
      if (memIsData) dm[memAddr[5:0]] <= memWrData[15:0];
      else           pm[memAddr[5:0]] <= memWrData;
      wrCount <= wrCount + 1;
    end
  end

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural model of the port state
  int  mAddr = 0;
  bit  mData = 0;
  bit  mHalf = 0;
  logic [15:0] mHold = '0;

  function automatic logic [15:0] modelRead();
    logic [15:0] v;
    if (mData) begin
      v = shDm[mAddr[5:0]]; mAddr++;
    end else if (!mHalf) begin
      v = shPm[mAddr[5:0]][23:8]; mHalf = 1;
    end else begin
      v = {8'h00, shPm[mAddr[5:0]][7:0]}; mHalf = 0; mAddr++;
    end
    return v;
  endfunction

  function automatic void modelWrite(input logic [15:0] d);
    if (mData) begin
      shDm[mAddr[5:0]] = d; mAddr++;
    end else if (!mHalf) begin
      mHold = d; mHalf = 1;
    end else begin
      shPm[mAddr[5:0]] = {mHold, d[7:0]}; mHalf = 0; mAddr++;
    end
  endfunction

  // R10: output enable follows the raw pins, compared every clock
  always @(posedge clk) begin
    #5;
    if (rstN && !finished)
      check(busOe == (!hostSelN && !hostRdN), "R10 busOe", busOe, !hostSelN && !hostRdN);
  end

  task automatic waitDone(input string tag);
    int n = 0;
    bit seen = 0;
    while (n < 60) begin
      @(negedge clk); n++;
      if (hostBusy) seen = 1;
      else if (seen) break;
    end
    check(seen && n < 60, tag, n, 0);
  endtask

  task automatic latch(input logic [15:0] v);
    @(negedge clk);
    busIn = v; hostSelN = 0; hostAleN = 0;
    repeat (4) @(negedge clk);
    hostSelN = 1; hostAleN = 1;
    repeat (2) @(negedge clk);
    mAddr = int'(v[13:0]); mData = v[14]; mHalf = 0;
  endtask

  task automatic coreWrite(input logic [15:0] v);
    @(negedge clk);
    coreCtlWr = 1; coreCtlData = v;
    @(negedge clk);
    coreCtlWr = 0;
    mAddr = int'(v[13:0]); mData = v[14]; mHalf = 0;
  endtask

  task automatic doRead(output logic [15:0] val);
    @(negedge clk);
    hostSelN = 0; hostRdN = 0;
    waitDone("R2 read completes");
    val = busOut;
    hostSelN = 1; hostRdN = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic doWrite(input logic [15:0] d);
    @(negedge clk);
    busIn = d; hostSelN = 0; hostWrN = 0;
    waitDone("R2 write completes");
    hostSelN = 1; hostWrN = 1;
    repeat (3) @(negedge clk);
    modelWrite(d);
  endtask

  function automatic bit memMatches();
    for (int i = 0; i < 64; i++)
      if (pm[i] !== shPm[i] || dm[i] !== shDm[i]) return 0;
    return 1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, e;
    int rc, wc;
    for (int i = 0; i < 64; i++) begin
      pm[i] = {8'(8'hA0 + i), 8'(i * 3), 8'(8'h5A ^ i)};
      dm[i] = 16'hC000 + 16'(i * 16'h0101);
      shPm[i] = pm[i];
      shDm[i] = dm[i];
    end
    repeat (5) @(negedge clk);
    check(hostBusy == 0, "R2 reset busy", hostBusy, 0);
    check(stealReq == 0, "R7 reset request", stealReq, 0);
    check(busOe == 0, "R10 reset oe", busOe, 0);
    check(ctlRegOut == 0, "R1 reset ctl", ctlRegOut, 0);
    rstN = 1;
    repeat (2) @(negedge clk);

    // R1: latch, bit 15 dropped
    latch(16'hC005);
    check(ctlRegOut == 16'h4005, "R1 latch fields", ctlRegOut, 16'h4005);

    // R3: data reads stream with increment
    for (int k = 0; k < 2; k++) begin
      doRead(v); e = modelRead();
      check(v == e, "R3 data read", v, e);
    end
    check(ctlRegOut[13:0] == 14'(mAddr), "R3 address step", ctlRegOut[13:0], mAddr);

    // R8: exact latency with grant held high
    @(negedge clk);
    hostSelN = 0; hostRdN = 0;
    e = modelRead();
    repeat (2) @(negedge clk);
    check(hostBusy == 0, "R8 busy before third edge", hostBusy, 0);
    @(negedge clk);
    check(hostBusy == 1, "R2 busy at third edge", hostBusy, 1);
    repeat (2) @(negedge clk);
    check(hostBusy == 0, "R8 busy low at fifth edge", hostBusy, 0);
    check(busOut == e, "R8 data at fifth edge", busOut, e);
    hostSelN = 1; hostRdN = 1;
    repeat (3) @(negedge clk);

    // R4: program word in two reads
    latch(16'h000A);
    rc = rdCount;
    doRead(v); e = modelRead();
    check(v == e, "R4 upper half", v, e);
    doRead(v); e = modelRead();
    check(v == e, "R4 low byte", v, e);
    check(rdCount - rc == 1, "R4 single memory read", rdCount - rc, 1);
    check(ctlRegOut[13:0] == 14'd11, "R4 address after pair", ctlRegOut[13:0], 11);

    // R3: data write
    latch(16'h4014);
    doWrite(16'hBEEF);
    check(dm[20] == 16'hBEEF, "R3 data write", dm[20], 16'hBEEF);
    check(ctlRegOut[13:0] == 14'd21, "R3 address after write", ctlRegOut[13:0], 21);

    // R5: program write halves, upper byte of second ignored
    latch(16'h001E);
    wc = wrCount;
    doWrite(16'h1357);
    check(wrCount == wc, "R5 first half no write", wrCount, wc);
    doWrite(16'hEE9A);
    check(pm[30] == 24'h13579A, "R5 merged word", pm[30], 24'h13579A);

    // R6: host re-latch discards pending half
    latch(16'h001F);
    wc = wrCount;
    doWrite(16'h2468);
    latch(16'h001F);
    check(wrCount == wc && pm[31] == shPm[31], "R6 discard on latch", pm[31], shPm[31]);
    doWrite(16'h1111);
    doWrite(16'h0022);
    check(pm[31] == 24'h111122, "R6 next is first half", pm[31], 24'h111122);

    // R6/R11: core write between read halves
    latch(16'h000C);
    doRead(v); e = modelRead();
    check(v == e, "R4 upper half before core write", v, e);
    coreWrite(16'h4028);
    check(ctlRegOut == 16'h4028, "R11 core load", ctlRegOut, 16'h4028);
    doRead(v); e = modelRead();
    check(v == e, "R6 read after core write", v, e);

    // R9: short read sees previous word while new fetch runs
    latch(16'h4032);
    doRead(v); e = modelRead();
    check(v == e, "R9 dummy read", v, e);
    @(negedge clk);
    hostSelN = 0; hostRdN = 0;
    repeat (3) @(negedge clk);
    check(hostBusy == 1 && busOut == e, "R9 previous word during fetch", busOut, e);
    waitDone("R9 fetch completes");
    e = modelRead();
    check(busOut == e, "R9 new word after fetch", busOut, e);
    hostSelN = 1; hostRdN = 1;
    repeat (3) @(negedge clk);

    // R7: hold-off without grant
    latch(16'h4037);
    stealGnt = 0;
    rc = rdCount;
    @(negedge clk);
    hostSelN = 0; hostRdN = 0;
    repeat (12) @(negedge clk);
    check(hostBusy && stealReq, "R7 held off", {hostBusy, stealReq}, 2'b11);
    check(rdCount == rc, "R7 no access without grant", rdCount, rc);
    stealGnt = 1;
    waitDone("R7 completes after grant");
    e = modelRead();
    check(busOut == e, "R7 data after grant", busOut, e);
    hostSelN = 1; hostRdN = 1;
    repeat (3) @(negedge clk);

    check(memMatches(), "R5 memory image", 0, 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule